// File: doc/BRIEF.md
# Exception State Register File

This block holds the exception bookkeeping of a simple 32-bit processor. It has four registers: the saved program counter of the faulting instruction, a cause register with an exception code and hardware interrupt pending bits, a faulting-address register, and a status register. The status register holds an eight-bit interrupt mask and a three-deep stack of mode/enable bit pairs. The processor pulses an exception strobe when it takes a trap. The block then saves the PC and the code, and saves the faulting address when the code is a memory-access code. It also pushes the mode stack, so the handler starts in kernel mode with interrupts off. A return strobe pops the stack.

Hardware interrupt request lines are recorded as sticky pending bits, whether or not interrupts are enabled. The block raises an interrupt request when the current enable bit is set and a pending level is unmasked. Software reads every register through a two-bit index port. It may write them only while the current mode bit shows kernel mode.

Top module: `exc_state_regs`

## Requirements
- R1: After reset, all four registers read 0, `userMode` is 0 and `irqReq` is 0.
- R2: When `excValid` is high at a clock edge, status bits 5:0 become the old bits 3:0 followed by two zero bits. The handler therefore runs in kernel mode (bit 1 = 0) with interrupts disabled (bit 0 = 0).
- R3: When `eretValid` is high at an edge without `excValid`, status bits 5:0 become {old 5:4, old 5:2}: the stack shifts right by two and bits 5:4 are kept. If both strobes are high, only the exception push happens.
- R4: On an exception, the saved-PC register takes `excPc` and cause bits 5:2 take `excCode`.
- R5: A high `hwIrq[i]` at an edge sets cause bit 10+i. The bit stays set whatever the enable and mask bits are, until a kernel write to the cause register with a 1 in bit 10+i clears it. A request high in that same cycle keeps the bit set.
- R6: `irqReq` is high exactly when status bit 0 is 1 and, for some level i, both cause bit 10+i and status mask bit 8+i are 1.
- R7: A software write is ignored while status bit 1 is 1 (user mode).
- R8: Register indices are 0 status, 1 cause, 2 saved PC, 3 faulting address. The writable fields are status bits 15:8 and 5:0, the write-one-to-clear cause pending bits, and all 32 saved-PC bits. The faulting-address register is read-only. All other bits read 0.
- R9: The faulting-address register takes `excAddr` on an exception only when the code is 4, 5, 6 or 7. For any other code it holds its value.
- R10: A software write in a cycle where `excValid` or `eretValid` is high is ignored.
- R11: `userMode` equals status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | Exception taken this cycle |
| excCode | input | 4 | Exception code |
| excPc | input | 32 | PC of the faulting instruction |
| excAddr | input | 32 | Faulting memory address |
| eretValid | input | 1 | Return from exception this cycle |
| hwIrq | input | 5 | Hardware interrupt request lines |
| regIdx | input | 2 | Software register index |
| regWrEn | input | 1 | Software write strobe |
| regWrData | input | 32 | Software write data |
| regRdData | output | 32 | Read data for `regIdx` |
| irqReq | output | 1 | Interrupt should be taken |
| userMode | output | 1 | Current mode bit (1 = user) |

## Verification
A corrupted stack shows on the next read of status and on `userMode`, one edge after the push or pop that caused it. That is why every one of the 64 stack values is pushed and popped. A lost or spurious pending bit shows on `irqReq` in the cycle after the request edge. The sweep over all mask and request combinations therefore compares `irqReq` directly after the pulse, then again after interrupts are disabled and after the bits are cleared. A wrongly gated write shows as a changed saved PC or status word on the next read.

// File: rtl/exc_state_pkg.sv
package exc_state_pkg;
  localparam int STACK_W = 6;
  localparam int MASK_LO = 8;
  localparam int MASK_W  = 8;
  localparam int PEND_LO = 10;
  localparam int CODE_LO = 2;
  localparam int CODE_W  = 4;

  localparam logic [1:0] IDX_STATUS = 2'd0;
  localparam logic [1:0] IDX_CAUSE  = 2'd1;
  localparam logic [1:0] IDX_EPC    = 2'd2;
  localparam logic [1:0] IDX_BAD    = 2'd3;

  typedef struct packed {
    logic takeExc;
    logic doEret;
    logic wrStatus;
    logic wrCause;
    logic wrEpc;
    logic loadBad;
  } ctrlStrobes_t;

  // codes 4..7 are the memory-access codes
  function automatic logic isMemCode(input logic [CODE_W-1:0] code);
    return code[CODE_W-1:2] == 2'b01;
  endfunction
endpackage

// File: rtl/exc_state_ctrl.sv
module exc_state_ctrl
  import exc_state_pkg::*;
(
  input  logic              excValid,
  input  logic              eretValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic              regWrEn,
  input  logic [1:0]        regIdx,
  input  logic              kernelMode,
  output ctrlStrobes_t      strobes
);
  logic swWrite;

  always_comb begin
    swWrite = regWrEn && kernelMode && !excValid && !eretValid;
    strobes.takeExc  = excValid;
    strobes.doEret   = eretValid && !excValid;
    strobes.wrStatus = swWrite && (regIdx == IDX_STATUS);
    strobes.wrCause  = swWrite && (regIdx == IDX_CAUSE);
    strobes.wrEpc    = swWrite && (regIdx == IDX_EPC);
    strobes.loadBad  = excValid && isMemCode(excCode);
  end
endmodule

// File: rtl/exc_state_dp.sv
module exc_state_dp
  import exc_state_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int HW_LEVELS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobes_t         strobes,
  input  logic [CODE_W-1:0]    excCode,
  input  logic [XLEN-1:0]      excPc,
  input  logic [XLEN-1:0]      excAddr,
  input  logic [HW_LEVELS-1:0] hwIrq,
  input  logic [XLEN-1:0]      wrData,
  output logic [XLEN-1:0]      statusWord,
  output logic [XLEN-1:0]      causeWord,
  output logic [XLEN-1:0]      epcWord,
  output logic [XLEN-1:0]      badWord,
  output logic                 irqReq,
  output logic                 kernelMode
);
  logic [STACK_W-1:0]   stackQ;
  logic [MASK_W-1:0]    maskQ;
  logic [HW_LEVELS-1:0] pendQ;
  logic [CODE_W-1:0]    codeQ;
  logic [XLEN-1:0]      epcQ;
  logic [XLEN-1:0]      badQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stackQ <= '0;
      maskQ  <= '0;
    end else begin
      if (strobes.takeExc)
        stackQ <= {stackQ[STACK_W-3:0], 2'b00};
      else if (strobes.doEret)
        stackQ <= {stackQ[STACK_W-1:STACK_W-2], stackQ[STACK_W-1:2]};
      else if (strobes.wrStatus)
        stackQ <= wrData[STACK_W-1:0];
      if (strobes.wrStatus)
        maskQ <= wrData[MASK_LO +: MASK_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codeQ <= '0;
      epcQ  <= '0;
      badQ  <= '0;
    end else begin
      if (strobes.takeExc) begin
        codeQ <= excCode;
        epcQ  <= excPc;
      end else if (strobes.wrEpc) begin
        epcQ  <= wrData;
      end
      if (strobes.loadBad)
        badQ <= excAddr;
    end
  end

  for (genvar lvl = 0; lvl < HW_LEVELS; lvl++) begin : g_pend
    logic clrBit;
    assign clrBit = strobes.wrCause && wrData[PEND_LO + lvl];
    always_ff @(posedge clk) begin
      if (!rst_n) pendQ[lvl] <= 1'b0;
      else        pendQ[lvl] <= hwIrq[lvl] || (pendQ[lvl] && !clrBit);
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[STACK_W-1:0]       = stackQ;
    statusWord[MASK_LO +: MASK_W] = maskQ;
    causeWord = '0;
    causeWord[CODE_LO +: CODE_W]     = codeQ;
    causeWord[PEND_LO +: HW_LEVELS]  = pendQ;
    epcWord = epcQ;
    badWord = badQ;
  end

  assign irqReq     = stackQ[0] && |(pendQ & maskQ[HW_LEVELS-1:0]);
  assign kernelMode = !stackQ[1];
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_state_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int HW_LEVELS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 excValid,
  input  logic [CODE_W-1:0]    excCode,
  input  logic [XLEN-1:0]      excPc,
  input  logic [XLEN-1:0]      excAddr,
  input  logic                 eretValid,
  input  logic [HW_LEVELS-1:0] hwIrq,
  input  logic [1:0]           regIdx,
  input  logic                 regWrEn,
  input  logic [XLEN-1:0]      regWrData,
  output logic [XLEN-1:0]      regRdData,
  output logic                 irqReq,
  output logic                 userMode
);
  ctrlStrobes_t    strobes;
  logic            kernelMode;
  logic [XLEN-1:0] statusWord, causeWord, epcWord, badWord;

  exc_state_ctrl u_ctrl (
    .excValid  (excValid),
    .eretValid (eretValid),
    .excCode   (excCode),
    .regWrEn   (regWrEn),
    .regIdx    (regIdx),
    .kernelMode(kernelMode),
    .strobes   (strobes)
  );

  exc_state_dp #(.XLEN(XLEN), .HW_LEVELS(HW_LEVELS)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .excCode   (excCode),
    .excPc     (excPc),
    .excAddr   (excAddr),
    .hwIrq     (hwIrq),
    .wrData    (regWrData),
    .statusWord(statusWord),
    .causeWord (causeWord),
    .epcWord   (epcWord),
    .badWord   (badWord),
    .irqReq    (irqReq),
    .kernelMode(kernelMode)
  );

  always_comb begin
    case (regIdx)
      IDX_STATUS: regRdData = statusWord;
      IDX_CAUSE:  regRdData = causeWord;
      IDX_EPC:    regRdData = epcWord;
      default:    regRdData = badWord;
    endcase
  end

  assign userMode = !kernelMode;
endmodule

// File: rtl/exc_state_chk.sv
module exc_state_chk
  import exc_state_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int HW_LEVELS = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 excValid,
  input logic                 eretValid,
  input logic [CODE_W-1:0]    excCode,
  input logic [XLEN-1:0]      excPc,
  input logic [XLEN-1:0]      excAddr,
  input logic [HW_LEVELS-1:0] hwIrq,
  input logic                 regWrEn,
  input logic                 irqReq,
  input logic [XLEN-1:0]      statusWord,
  input logic [XLEN-1:0]      causeWord,
  input logic [XLEN-1:0]      epcWord,
  input logic [XLEN-1:0]      badWord
);
  p_exc_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |=> statusWord[5:0] == {$past(statusWord[3:0]), 2'b00});

  p_eret_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eretValid && !excValid) |=>
      statusWord[5:0] == {$past(statusWord[5:4]), $past(statusWord[5:2])});

  p_epc_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |=> (epcWord == $past(excPc)) &&
                 (causeWord[CODE_LO +: CODE_W] == $past(excCode)));

  p_pending_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hwIrq != '0) |=>
      ((causeWord[PEND_LO +: HW_LEVELS] & $past(hwIrq)) == $past(hwIrq)));

  p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !statusWord[0] |-> !irqReq);

  p_irq_needs_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (causeWord[PEND_LO +: HW_LEVELS] &
                statusWord[MASK_LO +: HW_LEVELS]) != '0);

  p_user_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && statusWord[1] && !excValid && !eretValid) |=>
      $stable(epcWord) && $stable(statusWord));

  p_bad_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(excValid && excCode[3:2] == 2'b01) |=> $stable(badWord));

  p_bad_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid && excCode[3:2] == 2'b01) |=> badWord == $past(excAddr));
endmodule

bind exc_state_regs exc_state_chk #(.XLEN(XLEN), .HW_LEVELS(HW_LEVELS)) u_chk (.*);

// File: tb/exc_state_regs_tb.sv
module exc_state_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        excValid = 1'b0;
  logic [3:0]  excCode = '0;
  logic [31:0] excPc = '0;
  logic [31:0] excAddr = '0;
  logic        eretValid = 1'b0;
  logic [4:0]  hwIrq = '0;
  logic [1:0]  regIdx = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqReq;
  logic        userMode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  exc_state_regs u_dut (
    .clk(clk), .rst_n(rst_n), .excValid(excValid), .excCode(excCode),
    .excPc(excPc), .excAddr(excAddr), .eretValid(eretValid), .hwIrq(hwIrq),
    .regIdx(regIdx), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqReq(irqReq), .userMode(userMode)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; excValid = 0; eretValid = 0; hwIrq = '0; regWrEn = 0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic wrReg(input logic [1:0] idx, input logic [31:0] data);
    regIdx = idx; regWrData = data; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] idx, output logic [31:0] data);
    regIdx = idx;
    #1;
    data = regRdData;
  endtask

  task automatic takeExc(input logic [3:0] code, input logic [31:0] pc, input logic [31:0] addr);
    excValid = 1'b1; excCode = code; excPc = pc; excAddr = addr;
    tick();
    excValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    tick();
    doReset();
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rdReg(2'(i), rd);
      chk("R1 reg", rd, 32'd0);
    end
    chk("R1 userMode", {31'd0, userMode}, 32'd0);
    chk("R1 irqReq", {31'd0, irqReq}, 32'd0);

    // R2/R3/R11: all 64 stack values pushed then popped
    for (int s = 0; s < 64; s++) begin
      logic [5:0] sv, pv, ov;
      sv = 6'(s);
      pv = {sv[3:0], 2'b00};
      ov = {pv[5:4], pv[5:2]};
      doReset();
      wrReg(2'd0, {26'd0, sv});
      rdReg(2'd0, rd);
      chk("R8 status write", rd, {26'd0, sv});
      chk("R11 userMode", {31'd0, userMode}, {31'd0, sv[1]});
      takeExc(4'd8, 32'h100, 32'h0);
      rdReg(2'd0, rd);
      chk("R2 push", rd, {26'd0, pv});
      chk("R2 kernel after exc", {31'd0, userMode}, 32'd0);
      eretValid = 1'b1; tick(); eretValid = 1'b0;
      rdReg(2'd0, rd);
      chk("R3 pop", rd, {26'd0, ov});
      chk("R11 userMode after pop", {31'd0, userMode}, {31'd0, ov[1]});
    end

    // R4/R9: every exception code
    for (int c = 0; c < 16; c++) begin
      logic [31:0] pc, ad;
      pc = 32'h1000_0000 + 32'(c) * 4;
      ad = 32'hABC0_0000 | 32'(c + 1);
      doReset();
      takeExc(4'(c), pc, ad);
      rdReg(2'd1, rd); chk("R4 cause code", rd, 32'(c) << 2);
      rdReg(2'd2, rd); chk("R4 epc", rd, pc);
      rdReg(2'd3, rd); chk("R9 badaddr", rd, (c >= 4 && c <= 7) ? ad : 32'd0);
    end

    // R8: faulting address read-only, unused bits zero
    doReset();
    takeExc(4'd5, 32'h44, 32'h1234_5678);
    wrReg(2'd3, 32'hFFFF_FFFF);
    rdReg(2'd3, rd); chk("R8 badaddr read-only", rd, 32'h1234_5678);
    wrReg(2'd2, 32'hCAFE_F00D);
    rdReg(2'd2, rd); chk("R8 epc write", rd, 32'hCAFE_F00D);
    wrReg(2'd0, 32'hFFFF_FFFF);
    rdReg(2'd0, rd); chk("R8 status unused bits", rd, 32'h0000_FF3F);

    // R5/R6: every mask and request pattern
    for (int m = 0; m < 32; m++) begin
      for (int p = 0; p < 32; p++) begin
        logic expIrq;
        expIrq = (m & p) != 0;
        doReset();
        wrReg(2'd0, (32'(m) << 8) | 32'd1);
        hwIrq = 5'(p); tick(); hwIrq = '0; tick();
        rdReg(2'd1, rd); chk("R5 pending set", rd, 32'(p) << 10);
        chk("R6 irqReq enabled", {31'd0, irqReq}, {31'd0, expIrq});
        wrReg(2'd0, 32'(m) << 8);
        chk("R6 irqReq disabled", {31'd0, irqReq}, 32'd0);
        rdReg(2'd1, rd); chk("R5 pending held while disabled", rd, 32'(p) << 10);
        wrReg(2'd1, 32'h0000_FC00);
        rdReg(2'd1, rd); chk("R5 pending cleared", rd, 32'd0);
      end
    end

    // R5: clear and new request in the same cycle
    doReset();
    hwIrq = 5'b00001; tick();
    wrReg(2'd1, 32'h0000_0400);
    hwIrq = '0;
    rdReg(2'd1, rd); chk("R5 request beats clear", rd, 32'h0000_0400);

    // R7: user-mode writes ignored
    doReset();
    hwIrq = 5'b00100; tick(); hwIrq = '0;
    wrReg(2'd0, 32'h0000_0002);
    wrReg(2'd2, 32'h0000_1234);
    rdReg(2'd2, rd); chk("R7 epc unchanged in user", rd, 32'd0);
    wrReg(2'd0, 32'h0000_0000);
    rdReg(2'd0, rd); chk("R7 status unchanged in user", rd, 32'h0000_0002);
    wrReg(2'd1, 32'h0000_FC00);
    rdReg(2'd1, rd); chk("R7 cause unchanged in user", rd, 32'h0000_1000);

    // R10: write together with exception
    doReset();
    regIdx = 2'd2; regWrData = 32'h5555_0000; regWrEn = 1'b1;
    takeExc(4'd12, 32'h0000_0ABC, 32'h0);
    regWrEn = 1'b0;
    rdReg(2'd2, rd); chk("R10 write dropped on exc", rd, 32'h0000_0ABC);

    // R10: status write together with return
    doReset();
    wrReg(2'd0, 32'h0000_0004);
    regIdx = 2'd0; regWrData = 32'h0000_00FF; regWrEn = 1'b1; eretValid = 1'b1;
    tick();
    regWrEn = 1'b0; eretValid = 1'b0;
    rdReg(2'd0, rd); chk("R10 write dropped on eret", rd, 32'h0000_0001);

    // R3: both strobes, push wins
    doReset();
    wrReg(2'd0, 32'h0000_0005);
    eretValid = 1'b1;
    takeExc(4'd9, 32'h80, 32'h0);
    eretValid = 1'b0;
    rdReg(2'd0, rd); chk("R3 exc over eret", rd, 32'h0000_0014);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule